// File: doc/BRIEF.md
# Store-to-load overlap detector

The block remembers the address of the latest store in the current dispatch group and tells a scheduler, in the same cycle, whether a proposed load touches the same memory. An address is named by two operand tags: a base tag and an offset tag. The offset operand may also carry a known signed constant. A store is recorded with a capture strobe. A load is presented with a valid qualifier and the same fields. A combinational flag answers whether the load must be kept apart from the store.

Two kinds of hit are recognised. In a tag hit, the load names the same two operands as the recorded store, in either order. In a range hit, both sides use the same base tag and both offsets are constants, so the two byte ranges can be compared directly. A group-clear strobe empties the record when a new dispatch group starts.

Top module: `st_ld_overlap`

## Requirements
- R1: When a store is recorded and the valid load has the same base tag and the same offset tag as that store, overlap_o is high.
- R2: When the valid load's base tag equals the stored offset tag and its offset tag equals the stored base tag, overlap_o is high.
- R3: When the base tags match, both constant flags are set and the stored offset is less than the load offset (signed), overlap_o is high exactly when stored offset plus stored size is greater than the load offset.
- R4: When the base tags match, both constant flags are set and the stored offset is greater than or equal to the load offset, overlap_o is high exactly when load offset plus load size is greater than the stored offset.
- R5: The range test applies only when the base tags are equal and both constant flags are 1. Otherwise a load with no tag hit gives overlap_o low, whatever its constant value.
- R6: A record with size 0 counts as empty and keeps overlap_o low. A store captured with size 0 leaves the record empty. After reset the record is empty. Sizes are byte counts: 4 for a word and 8 for a double.
- R7: Each capture replaces the whole record, so only the latest store is compared. A new record takes effect in the cycle after its capture. A load in the capture cycle is compared with the previous record.
- R8: grp_clr_i empties the record from the next cycle. When st_cap_i is high in the same cycle, the capture wins and the new store is recorded.
- R9: overlap_o is a combinational function of the record and the load inputs. It is low whenever ld_vld_i is low.
- R10: Offsets are 16-bit two's complement. The range sums use 18-bit signed arithmetic and never wrap: a store at 32766 of size 8 overlaps a load at 32767, and a store at -32768 of size 8 does not overlap a load at 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_cap_i | input | 1 | Store capture strobe |
| st_base_i | input | TAG_W | Store base operand tag |
| st_ofs_tag_i | input | TAG_W | Store offset operand tag |
| st_ofs_const_i | input | 1 | Store offset is a known constant |
| st_ofs_val_i | input | OFS_W | Store constant offset, signed |
| st_size_i | input | SIZE_W | Store size in bytes |
| grp_clr_i | input | 1 | Dispatch group clear strobe |
| ld_vld_i | input | 1 | Load query valid |
| ld_base_i | input | TAG_W | Load base operand tag |
| ld_ofs_tag_i | input | TAG_W | Load offset operand tag |
| ld_ofs_const_i | input | 1 | Load offset is a known constant |
| ld_ofs_val_i | input | OFS_W | Load constant offset, signed |
| ld_size_i | input | SIZE_W | Load size in bytes |
| overlap_o | output | 1 | Load overlaps the recorded store |

## Verification
The bench uses the default parameters: TAG_W 6, OFS_W 16 and SIZE_W 4. With 16-bit offsets it can drive constants at both ends of the signed range, where an unextended sum would wrap. With 6-bit tags there is room for distinct base and offset tags in every swapped-order case. With a 4-bit size field, word and double accesses can be checked at the exact boundary, where the end of one range equals the start of the other.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    HIT_NONE  = 2'd0,
    HIT_EXACT = 2'd1,
    HIT_SWAP  = 2'd2,
    HIT_RANGE = 2'd3
  } hit_e;
endpackage

// File: rtl/ovl_store_rec.sv
module ovl_store_rec #(
  parameter int TAG_W  = 6,
  parameter int OFS_W  = 16,
  parameter int SIZE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              clr_i,
  input  logic [TAG_W-1:0]  base_i,
  input  logic [TAG_W-1:0]  ofs_tag_i,
  input  logic              ofs_const_i,
  input  logic [OFS_W-1:0]  ofs_val_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [TAG_W-1:0]  base_o,
  output logic [TAG_W-1:0]  ofs_tag_o,
  output logic              ofs_const_o,
  output logic [OFS_W-1:0]  ofs_val_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o      <= '0;
      ofs_tag_o   <= '0;
      ofs_const_o <= 1'b0;
      ofs_val_o   <= '0;
      size_o      <= '0;
    end else if (cap_i) begin
      // capture wins over a same-cycle clear
      base_o      <= base_i;
      ofs_tag_o   <= ofs_tag_i;
      ofs_const_o <= ofs_const_i;
      ofs_val_o   <= ofs_val_i;
      size_o      <= size_i;
    end else if (clr_i) begin
      size_o      <= '0;
    end
  end

  assign vld_o = |size_o;
endmodule

// File: rtl/ovl_range_cmp.sv
module ovl_range_cmp #(
  parameter int OFS_W  = 16,
  parameter int SIZE_W = 4
) (
  input  logic [OFS_W-1:0]  st_ofs_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic [OFS_W-1:0]  ld_ofs_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  output logic              hit_o
);
  // two guard bits keep offset+size from wrapping
  localparam int CMP_W = OFS_W + 2;
  localparam int SEXT  = CMP_W - OFS_W;
  localparam int ZEXT  = CMP_W - SIZE_W;

  logic signed [CMP_W-1:0] st_ofs_x, ld_ofs_x, st_sz_x, ld_sz_x;
  logic signed [CMP_W-1:0] st_end, ld_end;

  always_comb begin
    st_ofs_x = $signed({{SEXT{st_ofs_i[OFS_W-1]}}, st_ofs_i});
    ld_ofs_x = $signed({{SEXT{ld_ofs_i[OFS_W-1]}}, ld_ofs_i});
    st_sz_x  = $signed({{ZEXT{1'b0}}, st_size_i});
    ld_sz_x  = $signed({{ZEXT{1'b0}}, ld_size_i});
    st_end   = st_ofs_x + st_sz_x;
    ld_end   = ld_ofs_x + ld_sz_x;
    if (st_ofs_x < ld_ofs_x) hit_o = st_end > ld_ofs_x;
    else                     hit_o = ld_end > st_ofs_x;
  end
endmodule

// File: rtl/ovl_match.sv
module ovl_match
  import ovl_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int OFS_W  = 16,
  parameter int SIZE_W = 4
) (
  input  logic              rec_vld_i,
  input  logic [TAG_W-1:0]  rec_base_i,
  input  logic [TAG_W-1:0]  rec_ofs_tag_i,
  input  logic              rec_const_i,
  input  logic [OFS_W-1:0]  rec_ofs_val_i,
  input  logic [SIZE_W-1:0] rec_size_i,
  input  logic [TAG_W-1:0]  ld_base_i,
  input  logic [TAG_W-1:0]  ld_ofs_tag_i,
  input  logic              ld_const_i,
  input  logic [OFS_W-1:0]  ld_ofs_val_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  output hit_e              hit_o
);
  logic same_order, swap_order, range_ok, range_hit;

  ovl_range_cmp #(.OFS_W(OFS_W), .SIZE_W(SIZE_W)) i_range (
    .st_ofs_i  (rec_ofs_val_i),
    .st_size_i (rec_size_i),
    .ld_ofs_i  (ld_ofs_val_i),
    .ld_size_i (ld_size_i),
    .hit_o     (range_hit)
  );

  always_comb begin
    same_order = (ld_base_i == rec_base_i) && (ld_ofs_tag_i == rec_ofs_tag_i);
    swap_order = (ld_base_i == rec_ofs_tag_i) && (ld_ofs_tag_i == rec_base_i);
    range_ok   = (ld_base_i == rec_base_i) && rec_const_i && ld_const_i;
    hit_o      = HIT_NONE;
    if (rec_vld_i) begin
      if (same_order)                 hit_o = HIT_EXACT;
      else if (swap_order)            hit_o = HIT_SWAP;
      else if (range_ok && range_hit) hit_o = HIT_RANGE;
    end
  end
endmodule

// File: rtl/st_ld_overlap.sv
module st_ld_overlap
  import ovl_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int OFS_W  = 16,
  parameter int SIZE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_cap_i,
  input  logic [TAG_W-1:0]  st_base_i,
  input  logic [TAG_W-1:0]  st_ofs_tag_i,
  input  logic              st_ofs_const_i,
  input  logic [OFS_W-1:0]  st_ofs_val_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic              grp_clr_i,
  input  logic              ld_vld_i,
  input  logic [TAG_W-1:0]  ld_base_i,
  input  logic [TAG_W-1:0]  ld_ofs_tag_i,
  input  logic              ld_ofs_const_i,
  input  logic [OFS_W-1:0]  ld_ofs_val_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  output logic              overlap_o
);
  logic [TAG_W-1:0]  rec_base, rec_ofs_tag;
  logic              rec_const, rec_vld;
  logic [OFS_W-1:0]  rec_ofs_val;
  logic [SIZE_W-1:0] rec_size;
  hit_e              hit;

  ovl_store_rec #(.TAG_W(TAG_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W)) i_rec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (st_cap_i),
    .clr_i       (grp_clr_i),
    .base_i      (st_base_i),
    .ofs_tag_i   (st_ofs_tag_i),
    .ofs_const_i (st_ofs_const_i),
    .ofs_val_i   (st_ofs_val_i),
    .size_i      (st_size_i),
    .base_o      (rec_base),
    .ofs_tag_o   (rec_ofs_tag),
    .ofs_const_o (rec_const),
    .ofs_val_o   (rec_ofs_val),
    .size_o      (rec_size),
    .vld_o       (rec_vld)
  );

  ovl_match #(.TAG_W(TAG_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W)) i_match (
    .rec_vld_i     (rec_vld),
    .rec_base_i    (rec_base),
    .rec_ofs_tag_i (rec_ofs_tag),
    .rec_const_i   (rec_const),
    .rec_ofs_val_i (rec_ofs_val),
    .rec_size_i    (rec_size),
    .ld_base_i     (ld_base_i),
    .ld_ofs_tag_i  (ld_ofs_tag_i),
    .ld_const_i    (ld_ofs_const_i),
    .ld_ofs_val_i  (ld_ofs_val_i),
    .ld_size_i     (ld_size_i),
    .hit_o         (hit)
  );

  assign overlap_o = ld_vld_i && (hit != HIT_NONE);
endmodule

// File: rtl/ovl_chk.sv
module ovl_chk #(
  parameter int TAG_W  = 6,
  parameter int SIZE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              st_cap_i,
  input logic [TAG_W-1:0]  st_base_i,
  input logic [TAG_W-1:0]  st_ofs_tag_i,
  input logic [SIZE_W-1:0] st_size_i,
  input logic              grp_clr_i,
  input logic              ld_vld_i,
  input logic [TAG_W-1:0]  ld_base_i,
  input logic [TAG_W-1:0]  ld_ofs_tag_i,
  input logic              overlap_o
);
  // R1
  exact_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_cap_i) && ($past(st_size_i) != '0) && ld_vld_i &&
     (ld_base_i == $past(st_base_i)) && (ld_ofs_tag_i == $past(st_ofs_tag_i)))
    |-> overlap_o);

  // R2
  swap_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_cap_i) && ($past(st_size_i) != '0) && ld_vld_i &&
     (ld_base_i == $past(st_ofs_tag_i)) && (ld_ofs_tag_i == $past(st_base_i)))
    |-> overlap_o);

  // R6
  zero_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_cap_i && (st_size_i == '0)) |=> !overlap_o);

  // R8
  grp_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_clr_i && !st_cap_i) |=> !overlap_o);

  // R9
  ld_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_vld_i |-> !overlap_o);
endmodule

bind st_ld_overlap ovl_chk #(.TAG_W(TAG_W), .SIZE_W(SIZE_W)) i_ovl_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .st_cap_i     (st_cap_i),
  .st_base_i    (st_base_i),
  .st_ofs_tag_i (st_ofs_tag_i),
  .st_size_i    (st_size_i),
  .grp_clr_i    (grp_clr_i),
  .ld_vld_i     (ld_vld_i),
  .ld_base_i    (ld_base_i),
  .ld_ofs_tag_i (ld_ofs_tag_i),
  .overlap_o    (overlap_o)
);

// File: tb/test_st_ld_overlap.sv
module test_st_ld_overlap;
  typedef struct packed {
    logic [5:0]         base;
    logic [5:0]         otag;
    logic               c;
    logic signed [15:0] v;
    logic [3:0]         sz;
  } acc_t;

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_cap = 1'b0, st_c = 1'b0, clr = 1'b0, ld_vld = 1'b0, ld_c = 1'b0;
  logic [5:0] st_base = '0, st_otag = '0, ld_base = '0, ld_otag = '0;
  logic [15:0] st_v = '0, ld_v = '0;
  logic [3:0] st_sz = '0, ld_sz = '0;
  logic ovl;

  int checks = 0;
  int fails = 0;
  item_t q[$];
  acc_t m;
  bit done = 1'b0;

  always #4 clk = ~clk;

  st_ld_overlap i_st_ld_overlap (
    .clk_i(clk), .rst_ni(rst_n),
    .st_cap_i(st_cap), .st_base_i(st_base), .st_ofs_tag_i(st_otag),
    .st_ofs_const_i(st_c), .st_ofs_val_i(st_v), .st_size_i(st_sz),
    .grp_clr_i(clr),
    .ld_vld_i(ld_vld), .ld_base_i(ld_base), .ld_ofs_tag_i(ld_otag),
    .ld_ofs_const_i(ld_c), .ld_ofs_val_i(ld_v), .ld_size_i(ld_sz),
    .overlap_o(ovl)
  );

  function automatic logic model(acc_t r, logic vld, acc_t l);
    int so, lo;
    if (!vld || r.sz == 0) return 1'b0;
    if (l.base == r.base && l.otag == r.otag) return 1'b1;
    if (l.base == r.otag && l.otag == r.base) return 1'b1;
    if (l.base == r.base && r.c && l.c) begin
      so = int'(r.v);
      lo = int'(l.v);
      if (so < lo) return (so + int'(r.sz)) > lo;
      return (lo + int'(l.sz)) > so;
    end
    return 1'b0;
  endfunction

  function automatic acc_t mk(logic [5:0] b, logic [5:0] t, logic c, int v, int sz);
    acc_t a;
    a.base = b; a.otag = t; a.c = c; a.v = 16'(v); a.sz = 4'(sz);
    return a;
  endfunction

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(logic cap, acc_t s, logic gc, logic vld, acc_t l, string req);
    item_t it;
    @(negedge clk);
    st_cap = cap; st_base = s.base; st_otag = s.otag; st_c = s.c; st_v = s.v; st_sz = s.sz;
    clr = gc;
    ld_vld = vld; ld_base = l.base; ld_otag = l.otag; ld_c = l.c; ld_v = l.v; ld_sz = l.sz;
    it.exp = model(m, vld, l);
    it.req = req;
    q.push_back(it);
    if (cap) m = s;
    else if (gc) m.sz = '0;
  endtask

  task automatic store(acc_t s);
    step(1'b1, s, 1'b0, 1'b0, '0, "R9");
  endtask

  task automatic load(acc_t l, string req);
    step(1'b0, '0, 1'b0, 1'b1, l, req);
  endtask

  // monitor: compare away from the active edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (ovl !== it.exp) begin
          fails++;
          $display("FAIL %s: overlap_o=%b expected=%b", it.req, ovl, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6: empty after reset
    load(mk(1, 2, 0, 0, 4), "R6");
    load(mk(0, 0, 0, 0, 4), "R6");

    store(mk(3, 5, 0, 0, 4));
    load(mk(3, 5, 0, 0, 4), "R1");
    load(mk(5, 3, 0, 0, 4), "R2");
    load(mk(3, 6, 0, 0, 4), "R5");
    step(1'b0, '0, 1'b0, 1'b0, mk(3, 5, 0, 0, 4), "R9");

    store(mk(3, 5, 0, 0, 0));
    load(mk(3, 5, 0, 0, 4), "R6");

    store(mk(7, 10, 1, 100, 8));
    load(mk(7, 11, 1, 104, 4), "R3");
    load(mk(7, 11, 1, 107, 4), "R3");
    load(mk(7, 11, 1, 108, 4), "R3");
    load(mk(7, 11, 1, 96, 4), "R4");
    load(mk(7, 11, 1, 97, 4), "R4");
    load(mk(7, 11, 1, 100, 4), "R4");
    load(mk(7, 11, 0, 104, 4), "R5");
    load(mk(8, 11, 1, 104, 4), "R5");

    store(mk(7, 10, 1, 32766, 8));
    load(mk(7, 11, 1, 32767, 4), "R10");
    load(mk(7, 11, 1, -32768, 4), "R10");
    store(mk(7, 10, 1, -32768, 8));
    load(mk(7, 11, 1, 32767, 4), "R10");
    load(mk(7, 11, 1, -32761, 4), "R10");

    store(mk(3, 5, 0, 0, 4));
    store(mk(20, 21, 0, 0, 8));
    load(mk(3, 5, 0, 0, 4), "R7");
    load(mk(20, 21, 0, 0, 4), "R7");
    // R7: load in the capture cycle sees the previous record
    step(1'b1, mk(30, 31, 0, 0, 4), 1'b0, 1'b1, mk(30, 31, 0, 0, 4), "R7");
    load(mk(30, 31, 0, 0, 4), "R7");

    step(1'b0, '0, 1'b1, 1'b0, '0, "R8");
    load(mk(30, 31, 0, 0, 4), "R8");
    step(1'b1, mk(20, 21, 0, 0, 8), 1'b1, 1'b0, '0, "R8");
    load(mk(20, 21, 0, 0, 4), "R8");
    load(mk(21, 20, 0, 0, 4), "R8");

    step(1'b0, '0, 1'b0, 1'b0, '0, "R9");
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule